// File: doc/BRIEF.md
# Subroutine Usefulness History Predictor

This block keeps a per-subroutine history of whether speculative runs of that subroutine did useful prefetch work. It serves a core that runs ahead under a long-latency miss. The core tells the block about every return, giving the popped call PC and the useful flag carried with it, and about every call. For a call decoded in speculative mode, the block answers in the same cycle with an action. The action is to execute the call normally, to skip the body and continue at the fall-through address, or to stop the speculative thread. The block does not redirect the pipeline itself. It only presents the action and the target PC.

The history lives in a direct-mapped table. Each entry holds a valid bit, a tag, a 2-bit hysteresis counter and a post-return bit. The post-return bit records whether any L1 miss followed the last return from that subroutine. A small tracking state machine watches the window after each return. It has two states. In `TRK_IDLE` there is no subroutine to credit. In `TRK_WATCH` the previous-subroutine register holds a nonzero PC and misses are being collected.

The machine moves from `TRK_IDLE` to `TRK_WATCH` on a return with a nonzero PC. From `TRK_WATCH` it takes one of three paths:
- A return with a nonzero PC reloads the register and stays in `TRK_WATCH`.
- A return with PC zero goes back to `TRK_IDLE`.
- A call goes back to `TRK_IDLE`.

Each of these events in `TRK_WATCH` writes the post-return bit of the previous subroutine. A policy input picks how a zero counter is acted on.

Top module: `subr_usefulness_pred`

## Requirements
- R1: After reset the table holds no valid entry, so every speculative call returns the execute action (code 0) until a return has allocated its entry.
- R2: `action_valid_o` is 1 in exactly the cycles where `call_valid` and `spec_mode` are both 1, combinationally in that cycle. In all other cycles `action_o` is 0 and `target_pc_o` is 0.
- R3: A speculative call whose PC misses on the tag returns execute, whatever the policy.
- R4: A return whose PC misses on the tag allocates that entry. The counter starts at 2 and then takes the update, and the post-return bit is cleared.
- R5: A return that hits increments the counter when `ret_useful` is 1 and decrements it otherwise. The counter saturates at 0 and at 3. Only a counter of 0 marks the subroutine useless.
- R6: With `policy_sel` = 1 (skip), a call that hits an entry with counter 0 gives `action_o` = 1 (skip) and `target_pc_o` = `call_pc` + 4.
- R7: With `policy_sel` = 2 (stall), a call that hits an entry with counter 0 gives `action_o` = 2 (stall). In every case other than skip, `target_pc_o` is 0.
- R8: With `policy_sel` = 3 (hybrid), a call that hits an entry with counter 0 gives skip when that entry's post-return bit is 1 and stall when it is 0.
- R9: With `policy_sel` = 0 (off), every speculative call gives execute.
- R10: Every return loads the previous-subroutine register with `ret_pc` and clears the miss tracker. The next call (in any mode) or return writes the post-return bit of that previous entry, provided its tag still matches: the bit becomes 1 if `l1_miss` was high in any cycle after the return cycle, up to and including the closing cycle, and 0 otherwise. A previous PC of zero writes nothing. A call ends the window.
- R11: A lookup in the same cycle as a write to the same entry sees the value from before that write. The write is visible from the next cycle on.
- R12: The table index is `pc[7:2]` and the tag is `pc[31:8]` (default 64 entries, 32-bit PC). A return to a different tag at the same index evicts the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 2 | 0 off, 1 skip, 2 stall, 3 hybrid |
| spec_mode | input | 1 | Core is running speculatively |
| call_valid | input | 1 | A call is decoded this cycle |
| call_pc | input | PC_W | PC of the call instruction |
| ret_valid | input | 1 | A return pops a stack entry this cycle |
| ret_pc | input | PC_W | Call PC held in the popped entry |
| ret_useful | input | 1 | Useful flag held in the popped entry |
| l1_miss | input | 1 | An L1 miss was seen this cycle |
| action_valid_o | output | 1 | Action is meaningful this cycle |
| action_o | output | 2 | 0 execute, 1 skip, 2 stall |
| target_pc_o | output | PC_W | Fall-through PC when skipping, else 0 |

## Verification
The checker assumes that a call and a return never arrive in the same cycle, since the stack cannot push and pop at once. The random stimulus therefore picks at most one of the two events per cycle. The random PCs are drawn from four indices and four tags, so that hits, evictions, saturation at both ends and post-return writes all recur often. PC zero is included, which also exercises the case where no previous subroutine is tracked.

// File: rtl/subr_pred_pkg.sv
package subr_pred_pkg;

    typedef enum logic [1:0] {
        ACT_EXEC  = 2'd0,
        ACT_SKIP  = 2'd1,
        ACT_STALL = 2'd2
    } act_e;

    typedef enum logic [1:0] {
        POL_OFF    = 2'd0,
        POL_SKIP   = 2'd1,
        POL_STALL  = 2'd2,
        POL_HYBRID = 2'd3
    } pol_e;

    typedef enum logic {
        TRK_IDLE  = 1'b0,
        TRK_WATCH = 1'b1
    } trk_e;

    localparam logic [1:0] CTR_TOP  = 2'd3;
    localparam logic [1:0] CTR_INIT = 2'd2;

    function automatic logic [1:0] ctr_bump(input logic [1:0] c, input logic up);
        if (up) return (c == CTR_TOP) ? CTR_TOP : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

endpackage

// File: rtl/subr_hist_table.sv
module subr_hist_table
    import subr_pred_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [1:0]      lk_ctr,
    output logic            lk_post,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_useful,
    input  logic            post_en,
    input  logic [PC_W-1:0] post_pc,
    input  logic            post_val
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - 2;

    logic             vld_q  [ENTRIES];
    logic [TAG_W-1:0] tag_q  [ENTRIES];
    logic [1:0]       ctr_q  [ENTRIES];
    logic             post_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx, upd_idx, post_idx;
    logic [TAG_W-1:0] lk_tag, upd_tag, post_tag;

    assign lk_idx   = lk_pc[IDX_W+1:2];
    assign lk_tag   = lk_pc[PC_W-1:IDX_W+2];
    assign upd_idx  = upd_pc[IDX_W+1:2];
    assign upd_tag  = upd_pc[PC_W-1:IDX_W+2];
    assign post_idx = post_pc[IDX_W+1:2];
    assign post_tag = post_pc[PC_W-1:IDX_W+2];

    // Reads come from the registers, so a same-cycle write is not seen.
    always_comb begin
        lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_ctr  = ctr_q[lk_idx];
        lk_post = post_q[lk_idx];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                vld_q[i]  <= 1'b0;
                tag_q[i]  <= '0;
                ctr_q[i]  <= 2'd0;
                post_q[i] <= 1'b0;
            end else begin
                logic post_sel;
                post_sel = post_en && (post_idx == IDX_W'(i)) && vld_q[i] && (tag_q[i] == post_tag);
                if (upd_en && (upd_idx == IDX_W'(i))) begin
                    if (vld_q[i] && (tag_q[i] == upd_tag)) begin
                        ctr_q[i]  <= ctr_bump(ctr_q[i], upd_useful);
                        post_q[i] <= post_sel ? post_val : post_q[i];
                    end else begin
                        vld_q[i]  <= 1'b1;
                        tag_q[i]  <= upd_tag;
                        ctr_q[i]  <= ctr_bump(CTR_INIT, upd_useful);
                        post_q[i] <= 1'b0;
                    end
                end else if (post_sel) begin
                    post_q[i] <= post_val;
                end
            end
        end
    end

endmodule

// File: rtl/subr_post_track.sv
module subr_post_track
    import subr_pred_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_evt,
    input  logic            ret_evt,
    input  logic [PC_W-1:0] ret_pc,
    input  logic            l1_miss,
    output logic            post_en,
    output logic [PC_W-1:0] post_pc,
    output logic            post_val
);
    trk_e            state_q, state_d;
    logic [PC_W-1:0] prev_q;
    logic            miss_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: begin
                if (ret_evt && (ret_pc != '0)) state_d = TRK_WATCH;
            end
            TRK_WATCH: begin
                if (ret_evt)       state_d = (ret_pc != '0) ? TRK_WATCH : TRK_IDLE;
                else if (call_evt) state_d = TRK_IDLE;
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            prev_q  <= '0;
            miss_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ret_evt) prev_q <= ret_pc;
            if (ret_evt || call_evt)                 miss_q <= 1'b0;
            else if (state_q == TRK_WATCH && l1_miss) miss_q <= 1'b1;
        end
    end

    always_comb begin
        post_en  = (state_q == TRK_WATCH) && (call_evt || ret_evt);
        post_pc  = prev_q;
        post_val = miss_q || l1_miss;
    end

endmodule

// File: rtl/subr_action_sel.sv
module subr_action_sel
    import subr_pred_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            req,
    input  logic [1:0]      policy,
    input  logic            hit,
    input  logic [1:0]      ctr,
    input  logic            post,
    input  logic [PC_W-1:0] pc,
    output logic            act_valid,
    output logic [1:0]      act,
    output logic [PC_W-1:0] target
);
    act_e sel;
    pol_e pol;

    assign pol = pol_e'(policy);

    always_comb begin
        sel = ACT_EXEC;
        if (req && hit && (ctr == 2'd0)) begin
            unique case (pol)
                POL_OFF:    sel = ACT_EXEC;
                POL_SKIP:   sel = ACT_SKIP;
                POL_STALL:  sel = ACT_STALL;
                POL_HYBRID: sel = post ? ACT_SKIP : ACT_STALL;
                default:    sel = ACT_EXEC;
            endcase
        end
        act_valid = req;
        act       = sel;
        target    = (sel == ACT_SKIP) ? pc + PC_W'(4) : '0;
    end

endmodule

// File: rtl/subr_usefulness_pred.sv
module subr_usefulness_pred #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      policy_sel,
    input  logic            spec_mode,
    input  logic            call_valid,
    input  logic [PC_W-1:0] call_pc,
    input  logic            ret_valid,
    input  logic [PC_W-1:0] ret_pc,
    input  logic            ret_useful,
    input  logic            l1_miss,
    output logic            action_valid_o,
    output logic [1:0]      action_o,
    output logic [PC_W-1:0] target_pc_o
);
    logic            lk_hit, lk_post;
    logic [1:0]      lk_ctr;
    logic            post_en, post_val;
    logic [PC_W-1:0] post_pc;

    subr_hist_table #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_pc      (call_pc),
        .lk_hit     (lk_hit),
        .lk_ctr     (lk_ctr),
        .lk_post    (lk_post),
        .upd_en     (ret_valid),
        .upd_pc     (ret_pc),
        .upd_useful (ret_useful),
        .post_en    (post_en),
        .post_pc    (post_pc),
        .post_val   (post_val)
    );

    subr_post_track #(.PC_W(PC_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_evt (call_valid),
        .ret_evt  (ret_valid),
        .ret_pc   (ret_pc),
        .l1_miss  (l1_miss),
        .post_en  (post_en),
        .post_pc  (post_pc),
        .post_val (post_val)
    );

    subr_action_sel #(.PC_W(PC_W)) u_sel (
        .req       (call_valid && spec_mode),
        .policy    (policy_sel),
        .hit       (lk_hit),
        .ctr       (lk_ctr),
        .post      (lk_post),
        .pc        (call_pc),
        .act_valid (action_valid_o),
        .act       (action_o),
        .target    (target_pc_o)
    );

endmodule

// File: rtl/subr_pred_checker.sv
module subr_pred_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      policy_sel,
    input logic            spec_mode,
    input logic            call_valid,
    input logic [PC_W-1:0] call_pc,
    input logic            ret_valid,
    input logic            action_valid_o,
    input logic [1:0]      action_o,
    input logic [PC_W-1:0] target_pc_o
);
    // Input assumption: the stack never pushes and pops in the same cycle.
    assert_call_ret_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({call_valid, ret_valid}));

    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(call_valid && spec_mode) |-> (!action_valid_o && action_o == 2'd0 && target_pc_o == '0));

    assert_off_executes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (action_valid_o && policy_sel == 2'd0) |-> action_o == 2'd0);

    assert_skip_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (action_o == 2'd1) |-> (target_pc_o == call_pc + PC_W'(4) && (policy_sel == 2'd1 || policy_sel == 2'd3)));

    assert_stall_policy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (action_o == 2'd2) |-> ((policy_sel == 2'd2 || policy_sel == 2'd3) && target_pc_o == '0));

    assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        action_o != 2'd3);

endmodule

bind subr_usefulness_pred subr_pred_checker #(.PC_W(PC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .policy_sel     (policy_sel),
    .spec_mode      (spec_mode),
    .call_valid     (call_valid),
    .call_pc        (call_pc),
    .ret_valid      (ret_valid),
    .action_valid_o (action_valid_o),
    .action_o       (action_o),
    .target_pc_o    (target_pc_o)
);

// File: tb/subr_usefulness_pred_test.sv
module subr_usefulness_pred_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  policy_sel = 2'd0;
    logic        spec_mode = 1'b0, call_valid = 1'b0, ret_valid = 1'b0;
    logic        ret_useful = 1'b0, l1_miss = 1'b0;
    logic [31:0] call_pc = '0, ret_pc = '0;
    logic        action_valid_o;
    logic [1:0]  action_o;
    logic [31:0] target_pc_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Bench model of the table (index pc[7:2], tag pc[31:8]).
    bit          m_vld [64];
    logic [23:0] m_tag [64];
    logic [1:0]  m_ctr [64];
    bit          m_post[64];
    logic [31:0] m_prev;
    bit          m_prev_on;
    bit          m_miss;

    always #4 clk = ~clk;

    subr_usefulness_pred uut (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .spec_mode(spec_mode),
        .call_valid(call_valid), .call_pc(call_pc), .ret_valid(ret_valid),
        .ret_pc(ret_pc), .ret_useful(ret_useful), .l1_miss(l1_miss),
        .action_valid_o(action_valid_o), .action_o(action_o), .target_pc_o(target_pc_o)
    );

    function automatic logic [1:0] sat(input logic [1:0] c, input bit up);
        if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    function automatic bit m_hit(input logic [31:0] pc);
        return m_vld[pc[7:2]] && (m_tag[pc[7:2]] == pc[31:8]);
    endfunction

    function automatic logic [1:0] exp_act(input bit c, input bit sp, input logic [31:0] pc,
                                           input logic [1:0] pol);
        if (!(c && sp) || !m_hit(pc) || pol == 2'd0 || m_ctr[pc[7:2]] != 2'd0) return 2'd0;
        if (pol == 2'd1) return 2'd1;
        if (pol == 2'd2) return 2'd2;
        return m_post[pc[7:2]] ? 2'd1 : 2'd2;
    endfunction

    task automatic step(input bit c, input logic [31:0] cpc, input bit sp, input bit r,
                        input logic [31:0] rpc, input bit use_f, input bit ms,
                        input logic [1:0] pol, input string req);
        logic [1:0]  ea;
        logic [31:0] et;
        bit          ev;
        @(negedge clk);
        call_valid = c; call_pc = cpc; spec_mode = sp; ret_valid = r; ret_pc = rpc;
        ret_useful = use_f; l1_miss = ms; policy_sel = pol;
        #1;
        ev = c && sp;
        ea = exp_act(c, sp, cpc, pol);
        et = (ea == 2'd1) ? cpc + 32'd4 : 32'd0;
        total++;
        if (action_valid_o !== ev || action_o !== ea || target_pc_o !== et) begin
            bad++;
            $display("FAIL %s: pc=%h got valid=%0b act=%0d tgt=%h expected valid=%0b act=%0d tgt=%h",
                     req, cpc, action_valid_o, action_o, target_pc_o, ev, ea, et);
        end
        // model update at the coming edge
        if ((c || r) && m_prev_on && m_hit(m_prev)) m_post[m_prev[7:2]] = m_miss || ms;
        if (r) begin
            if (m_hit(rpc)) m_ctr[rpc[7:2]] = sat(m_ctr[rpc[7:2]], use_f);
            else begin
                m_vld[rpc[7:2]]  = 1'b1;
                m_tag[rpc[7:2]]  = rpc[31:8];
                m_ctr[rpc[7:2]]  = sat(2'd2, use_f);
                m_post[rpc[7:2]] = 1'b0;
            end
            m_prev = rpc; m_prev_on = (rpc != 0); m_miss = 1'b0;
        end else if (c) begin
            m_prev_on = 1'b0; m_miss = 1'b0;
        end else if (m_prev_on && ms) m_miss = 1'b1;
    endtask

    task automatic do_call(input logic [31:0] pc, input bit sp, input logic [1:0] pol, input string req);
        step(1'b1, pc, sp, 1'b0, 32'd0, 1'b0, 1'b0, pol, req);
    endtask

    task automatic do_ret(input logic [31:0] pc, input bit use_f, input string req);
        step(1'b0, 32'd0, 1'b1, 1'b1, pc, use_f, 1'b0, 2'd0, req);
    endtask

    task automatic do_idle(input bit ms, input string req);
        step(1'b0, 32'd0, 1'b1, 1'b0, 32'd0, 1'b0, ms, 2'd0, req);
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [31:0] PA = 32'h0000_0104;
    localparam logic [31:0] PB = 32'h0000_0204;  // same index as PA, other tag

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_ctr[i] = '0; m_post[i] = 0; end
        m_prev = '0; m_prev_on = 0; m_miss = 0;
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (action_valid_o !== 1'b0 || action_o !== 2'd0) begin
            bad++;
            $display("FAIL R2 reset: got valid=%0b act=%0d expected 0 0", action_valid_o, action_o);
        end
        @(negedge clk); rst_n = 1'b1;

        do_call(PA, 1, 2'd1, "R1 empty table executes");
        do_call(PA, 1, 2'd2, "R3 tag miss executes");
        do_ret(PA, 0, "R4 allocate at 2 then down");
        do_ret(PA, 0, "R5 decrement to zero");
        do_call(PA, 1, 2'd1, "R6 skip with fall-through");
        do_call(PA, 1, 2'd2, "R7 stall");
        do_call(PA, 1, 2'd0, "R9 off executes");
        do_call(PA, 0, 2'd1, "R2 non-speculative call");
        do_call(PA, 1, 2'd3, "R8 hybrid post bit 0 stalls");
        do_ret(PA, 0, "R5 saturate at zero");
        do_idle(1, "R10 miss after return");
        do_call(PA, 1, 2'd3, "R11 lookup sees old post bit");
        do_call(PA, 1, 2'd3, "R8 hybrid post bit 1 skips");
        do_ret(PA, 1, "R5 increment");
        do_ret(PA, 1, "R5 increment");
        do_ret(PA, 1, "R5 increment");
        do_ret(PA, 1, "R5 saturate at three");
        do_ret(PA, 0, "R5 down from three");
        do_call(PA, 1, 2'd1, "R5 nonzero counter executes");
        do_ret(PB, 0, "R12 evict by other tag");
        do_ret(PB, 0, "R12 second down");
        do_call(PA, 1, 2'd1, "R12 evicted tag executes");
        do_call(PB, 1, 2'd1, "R12 new tag skips");
        do_ret(32'd0, 0, "R10 zero previous");
        do_idle(1, "R10 miss with nothing tracked");
        do_call(PB, 1, 2'd3, "R10 no write on zero previous");

        for (int n = 0; n < 4000; n++) begin
            int unsigned kind;
            logic [31:0] pc;
            kind = $urandom_range(0, 3);
            pc = {22'd0, 2'($urandom_range(0, 3)), 4'd0, 2'($urandom_range(0, 3)), 2'b00};
            case (kind)
                0: step(1'b1, pc, 1'($urandom_range(0, 3) != 0), 1'b0, 32'd0, 1'b0,
                        1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), "R6 R7 R8 random call");
                1: step(1'b0, 32'd0, 1'($urandom_range(0, 1)), 1'b1, pc, 1'($urandom_range(0, 2) == 0),
                        1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), "R4 R5 random return");
                default: step(1'b0, 32'd0, 1'b1, 1'b0, 32'd0, 1'b0,
                        1'($urandom_range(0, 5) == 0), 2'($urandom_range(0, 3)), "R10 random idle");
            endcase
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule